// File: doc/BRIEF.md
# Inclusive Last-Level Cache Directory Controller

This block is the tag and directory controller of a shared last-level cache that is inclusive of every private cache above it. Each stored line keeps its tag, a presence vector with one bit per core, an ownership flag (set when a single core may hold the line writable) and a dirty flag for the shared copy. Because inclusion holds, a lookup miss proves that no core has the line. The request then goes straight to memory, and the controller probes no core.

On a hit, the controller probes only the cores whose presence bits are set, and only when it needs to. A read of a line that another core owns sends one downgrade probe to that owner. A read-for-ownership invalidates every other holder. A read of a line that is already shared is served with no probe. When a valid line must be replaced, every recorded holder is back-invalidated first. Dirty data, whether recorded earlier or returned by the probe acknowledgements, is written to memory before the new line is fetched.

Requests are handled one at a time, so a second request to any line, the same line included, waits until the first completes. Probes are issued one at a time, and each waits for its acknowledgement. Memory is modelled as a request that waits for an acknowledge.

Top module: `incl_dir_ctrl`

## Requirements
- R1: After reset, req_ready is high and prb_valid, mem_valid and rsp_valid are low. No line is present, so the first access to any address misses.
- R2: A read (op 0) or read-for-ownership that misses while the chosen way is empty issues exactly one memory read (mem_write 0) of the requested address and no probe. It then responds with rsp_src 2 (memory) and rsp_excl 1.
- R3: A read hit on a line that is not owned by another core is answered with no probe and no memory request, with rsp_src 0 (shared cache).
- R4: A read hit on a line owned by another core sends exactly one probe with prb_inval 0 (downgrade) to that owner, then responds with rsp_src 1 (probed) and rsp_excl 0.
- R5: A dirty probe acknowledgement or a writeback marks the stored line dirty. When a dirty line is replaced, a memory write (mem_write 1) of its address follows all back-invalidations and precedes the memory read of the new line.
- R6: A read-for-ownership (op 1) that hits sends a probe with prb_inval 1 to every other holder, in ascending core order, and none to the requester. It responds with rsp_excl 1, and rsp_src 1 if any probe was sent, else 0.
- R7: Replacing a valid line sends a prb_inval 1 probe to each core whose presence bit is set, in ascending order, before any memory request. A clean victim whose holders all acknowledge clean causes no memory write.
- R8: A writeback (op 2) or eviction notice (op 3) clears the requester's presence bit, with no probe and no memory request. It responds with rsp_src 0 and rsp_excl 0.
- R9: Only one transaction is in flight: req_ready stays low from acceptance until the response cycle. In any cycle, at most one of prb_valid, mem_valid and rsp_valid is high.
- R10: The victim is the lowest-numbered empty way of the set. If the set has no empty way, the victim is taken from a per-set round-robin pointer that moves past the way filled last.
- R11: rsp_excl is 1 exactly when the requester is the only core holding the line after the request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_core | input | $clog2(NCORE) | Requesting core |
| req_op | input | 2 | 0 read, 1 read-for-ownership, 2 writeback, 3 eviction notice |
| req_addr | input | ADDR_W | Line address |
| rsp_valid | output | 1 | Response pulse |
| rsp_core | output | $clog2(NCORE) | Core being answered |
| rsp_addr | output | ADDR_W | Line address answered |
| rsp_src | output | 2 | 0 shared cache, 1 after probe, 2 memory |
| rsp_excl | output | 1 | Line granted to the requester alone |
| prb_valid | output | 1 | Probe pulse toward a core |
| prb_core | output | $clog2(NCORE) | Probed core |
| prb_addr | output | ADDR_W | Probed line address |
| prb_inval | output | 1 | 1 invalidate, 0 downgrade to shared |
| prb_ack | input | 1 | Probe acknowledgement |
| prb_ack_dirty | input | 1 | Acknowledgement carries modified data |
| mem_valid | output | 1 | Memory request pulse |
| mem_write | output | 1 | 1 write back, 0 read |
| mem_addr | output | ADDR_W | Memory line address |
| mem_ack | input | 1 | Memory request completed |

## Verification
The hardest case to reach is the replacement of a line that is both dirty and still held by a core. It needs a dirty probe acknowledgement on an earlier hit, several further requests that move ownership while keeping the dirty flag, and a set filled so that the round-robin pointer lands on that exact way. The bench uses a two-set, two-way configuration. It walks one set through that history with a fixed address sequence whose victim ways it works out from the pointer rule. It then checks the full ordered list of probe, write and read events that the replacement emits. A second set is swept with reads from every core and a final read-for-ownership, to cover each presence-vector shape.

// File: rtl/sf_pkg.sv
package sf_pkg;
   typedef enum logic [1:0] {
      OP_RD    = 2'd0,
      OP_RFO   = 2'd1,
      OP_WB    = 2'd2,
      OP_EVICT = 2'd3
   } sf_op_e;

   typedef enum logic [1:0] {
      SRC_LLC   = 2'd0,
      SRC_PROBE = 2'd1,
      SRC_MEM   = 2'd2
   } sf_src_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_LOOK, ST_PRB, ST_PWAIT,
      ST_MWR, ST_MWRW, ST_MRD, ST_MRDW, ST_FIN
   } sf_state_e;
endpackage

// File: rtl/sf_pick_lowest.sv
module sf_pick_lowest #(
   parameter int N = 4,
   localparam int IW = (N > 1) ? $clog2(N) : 1
) (
   input  logic [N-1:0]  mask,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (mask[i]) idx = IW'(i);
      end
   end
   assign any = |mask;
endmodule

// File: rtl/sf_victim_rr.sv
module sf_victim_rr #(
   parameter int SETS = 4,
   parameter int WAYS = 2,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [IDX_W-1:0] set,
   input  logic [WAYS-1:0]  way_vld,
   output logic [WAY_W-1:0] victim,
   input  logic             adv,
   input  logic [WAY_W-1:0] adv_way
);
   generate
      if (WAYS == 1) begin : g_direct
         assign victim = '0;
      end else begin : g_rr
         logic [WAY_W-1:0] ptr_q [SETS];

         always_comb begin
            logic found;
            found  = 1'b0;
            victim = ptr_q[set];
            for (int w = 0; w < WAYS; w++) begin
               if (!found && !way_vld[w]) begin
                  victim = WAY_W'(w);
                  found  = 1'b1;
               end
            end
         end

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < SETS; s++) ptr_q[s] <= '0;
            end else if (adv) begin
               ptr_q[set] <= (adv_way == WAY_W'(WAYS - 1)) ? '0 : adv_way + 1'b1;
            end
         end
      end
   endgenerate
endmodule

// File: rtl/sf_dir_store.sv
module sf_dir_store #(
   parameter int SETS  = 4,
   parameter int WAYS  = 2,
   parameter int TAG_W = 6,
   parameter int NCORE = 4,
   localparam int IDX_W = $clog2(SETS),
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic                        clk,
   input  logic                        rst_n,
   input  logic [IDX_W-1:0]            rd_set,
   output logic [WAYS-1:0]             rd_vld,
   output logic [WAYS-1:0][TAG_W-1:0]  rd_tag,
   output logic [WAYS-1:0][NCORE-1:0]  rd_pres,
   output logic [WAYS-1:0]             rd_own,
   output logic [WAYS-1:0]             rd_dirty,
   input  logic                        wr_en,
   input  logic [IDX_W-1:0]            wr_set,
   input  logic [WAY_W-1:0]            wr_way,
   input  logic [TAG_W-1:0]            wr_tag,
   input  logic [NCORE-1:0]            wr_pres,
   input  logic                        wr_own,
   input  logic                        wr_dirty
);
   logic [WAYS-1:0]  vld_q   [SETS];
   logic [WAYS-1:0]  own_q   [SETS];
   logic [WAYS-1:0]  dirty_q [SETS];
   logic [TAG_W-1:0] tag_q   [SETS][WAYS];
   logic [NCORE-1:0] pres_q  [SETS][WAYS];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int s = 0; s < SETS; s++) begin
            vld_q[s]   <= '0;
            own_q[s]   <= '0;
            dirty_q[s] <= '0;
            for (int w = 0; w < WAYS; w++) begin
               tag_q[s][w]  <= '0;
               pres_q[s][w] <= '0;
            end
         end
      end else if (wr_en) begin
         vld_q[wr_set][wr_way]   <= 1'b1;
         own_q[wr_set][wr_way]   <= wr_own;
         dirty_q[wr_set][wr_way] <= wr_dirty;
         tag_q[wr_set][wr_way]   <= wr_tag;
         pres_q[wr_set][wr_way]  <= wr_pres;
      end
   end

   for (genvar w = 0; w < WAYS; w++) begin : g_rd
      assign rd_vld[w]   = vld_q[rd_set][w];
      assign rd_own[w]   = own_q[rd_set][w];
      assign rd_dirty[w] = dirty_q[rd_set][w];
      assign rd_tag[w]   = tag_q[rd_set][w];
      assign rd_pres[w]  = pres_q[rd_set][w];

      // R4: an owned line is recorded in exactly one core
      p_owner_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
         (rd_vld[w] && rd_own[w]) |-> ($countones(rd_pres[w]) == 1))
         else $error("owned line with presence count other than one");
   end
endmodule

// File: rtl/incl_dir_ctrl.sv
module incl_dir_ctrl #(
   parameter int NCORE  = 4,
   parameter int ADDR_W = 10,
   parameter int SETS   = 8,
   parameter int WAYS   = 4,
   localparam int CID_W = $clog2(NCORE),
   localparam int IDX_W = $clog2(SETS),
   localparam int TAG_W = ADDR_W - IDX_W,
   localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   output logic              req_ready,
   input  logic [CID_W-1:0]  req_core,
   input  logic [1:0]        req_op,
   input  logic [ADDR_W-1:0] req_addr,
   output logic              rsp_valid,
   output logic [CID_W-1:0]  rsp_core,
   output logic [ADDR_W-1:0] rsp_addr,
   output logic [1:0]        rsp_src,
   output logic              rsp_excl,
   output logic              prb_valid,
   output logic [CID_W-1:0]  prb_core,
   output logic [ADDR_W-1:0] prb_addr,
   output logic              prb_inval,
   input  logic              prb_ack,
   input  logic              prb_ack_dirty,
   output logic              mem_valid,
   output logic              mem_write,
   output logic [ADDR_W-1:0] mem_addr,
   input  logic              mem_ack
);
   import sf_pkg::*;

   if (NCORE < 2) begin : g_bad_ncore
      $error("NCORE must be at least 2");
   end
   if (SETS < 2 || (SETS & (SETS - 1)) != 0) begin : g_bad_sets
      $error("SETS must be a power of two, at least 2");
   end
   if (WAYS < 1) begin : g_bad_ways
      $error("WAYS must be at least 1");
   end
   if (TAG_W < 1) begin : g_bad_tag
      $error("ADDR_W must exceed the index width");
   end

   sf_state_e          state_q;
   sf_op_e             q_op;
   logic [CID_W-1:0]   q_core, q_pcore;
   logic [ADDR_W-1:0]  q_addr;
   logic [WAY_W-1:0]   q_way;
   logic [TAG_W-1:0]   q_vtag;
   logic               q_hit, q_fill, q_evict, q_probed, q_inval, q_dirty;
   logic [NCORE-1:0]   pmask;

   logic [IDX_W-1:0]   set;
   logic [TAG_W-1:0]   tag;
   logic [NCORE-1:0]   rb;
   assign set = q_addr[IDX_W-1:0];
   assign tag = q_addr[ADDR_W-1:IDX_W];
   assign rb  = NCORE'(1) << q_core;

   logic [WAYS-1:0]             rd_vld, rd_own, rd_dirty;
   logic [WAYS-1:0][TAG_W-1:0]  rd_tag;
   logic [WAYS-1:0][NCORE-1:0]  rd_pres;
   logic                        wr_en, wr_own, wr_dirty;
   logic [NCORE-1:0]            wr_pres;
   logic [WAY_W-1:0]            vict;
   logic [CID_W-1:0]            p_idx;
   logic                        p_any;

   sf_dir_store #(.SETS(SETS), .WAYS(WAYS), .TAG_W(TAG_W), .NCORE(NCORE)) u_store (
      .clk, .rst_n, .rd_set(set), .rd_vld, .rd_tag, .rd_pres, .rd_own, .rd_dirty,
      .wr_en, .wr_set(set), .wr_way(q_way), .wr_tag(tag), .wr_pres, .wr_own, .wr_dirty
   );

   sf_victim_rr #(.SETS(SETS), .WAYS(WAYS)) u_vict (
      .clk, .rst_n, .set, .way_vld(rd_vld), .victim(vict),
      .adv(state_q == ST_FIN && q_fill), .adv_way(q_way)
   );

   sf_pick_lowest #(.N(NCORE)) u_pick (.mask(pmask), .idx(p_idx), .any(p_any));

   // tag compare, one comparator per way
   logic [WAYS-1:0]  hit_vec;
   logic [WAY_W-1:0] hit_way;
   logic             any_hit;
   for (genvar w = 0; w < WAYS; w++) begin : g_cmp
      assign hit_vec[w] = rd_vld[w] && (rd_tag[w] == tag);
   end
   always_comb begin
      hit_way = '0;
      for (int w = 0; w < WAYS; w++) begin
         if (hit_vec[w]) hit_way = WAY_W'(w);
      end
   end
   assign any_hit = |hit_vec;

   logic [NCORE-1:0] look_others;
   assign look_others = rd_pres[hit_way] & ~rb;

   // sequencing
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q  <= ST_IDLE;
         q_op     <= OP_RD;
         q_core   <= '0;
         q_pcore  <= '0;
         q_addr   <= '0;
         q_way    <= '0;
         q_vtag   <= '0;
         q_hit    <= 1'b0;
         q_fill   <= 1'b0;
         q_evict  <= 1'b0;
         q_probed <= 1'b0;
         q_inval  <= 1'b0;
         q_dirty  <= 1'b0;
         pmask    <= '0;
      end else begin
         case (state_q)
            ST_IDLE: if (req_valid) begin
               q_op     <= sf_op_e'(req_op);
               q_core   <= req_core;
               q_addr   <= req_addr;
               q_probed <= 1'b0;
               q_hit    <= 1'b0;
               q_fill   <= 1'b0;
               q_evict  <= 1'b0;
               q_dirty  <= 1'b0;
               pmask    <= '0;
               state_q  <= ST_LOOK;
            end
            ST_LOOK: begin
               if (any_hit) begin
                  q_way   <= hit_way;
                  q_hit   <= 1'b1;
                  state_q <= ST_FIN;
                  if (q_op == OP_RD && rd_own[hit_way] && look_others != '0) begin
                     pmask    <= look_others;
                     q_inval  <= 1'b0;
                     q_probed <= 1'b1;
                     state_q  <= ST_PRB;
                  end else if (q_op == OP_RFO && look_others != '0) begin
                     pmask    <= look_others;
                     q_inval  <= 1'b1;
                     q_probed <= 1'b1;
                     state_q  <= ST_PRB;
                  end
               end else if (q_op == OP_RD || q_op == OP_RFO) begin
                  q_fill  <= 1'b1;
                  q_way   <= vict;
                  q_vtag  <= rd_tag[vict];
                  q_evict <= rd_vld[vict];
                  q_dirty <= rd_vld[vict] && rd_dirty[vict];
                  pmask   <= rd_vld[vict] ? rd_pres[vict] : '0;
                  q_inval <= 1'b1;
                  state_q <= ST_PRB;
               end else begin
                  state_q <= ST_FIN;
               end
            end
            ST_PRB: begin
               if (p_any) begin
                  q_pcore <= p_idx;
                  state_q <= ST_PWAIT;
               end else if (q_fill) begin
                  state_q <= (q_evict && q_dirty) ? ST_MWR : ST_MRD;
               end else begin
                  state_q <= ST_FIN;
               end
            end
            ST_PWAIT: if (prb_ack) begin
               pmask[q_pcore] <= 1'b0;
               q_dirty        <= q_dirty | prb_ack_dirty;
               state_q        <= ST_PRB;
            end
            ST_MWR:  state_q <= ST_MWRW;
            ST_MWRW: if (mem_ack) state_q <= ST_MRD;
            ST_MRD:  state_q <= ST_MRDW;
            ST_MRDW: if (mem_ack) state_q <= ST_FIN;
            ST_FIN:  state_q <= ST_IDLE;
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   // directory update and response in the final cycle
   logic [NCORE-1:0] cur_pres, base_pres;
   logic             fin_excl;
   assign cur_pres  = rd_pres[q_way];
   assign base_pres = q_fill ? '0 : cur_pres;

   always_comb begin
      wr_dirty = q_fill ? 1'b0 : (rd_dirty[q_way] | q_dirty);
      case (q_op)
         OP_RD: begin
            wr_pres  = base_pres | rb;
            wr_own   = (wr_pres == rb);
            fin_excl = wr_own;
         end
         OP_RFO: begin
            wr_pres  = rb;
            wr_own   = 1'b1;
            fin_excl = 1'b1;
         end
         default: begin
            wr_pres  = cur_pres & ~rb;
            wr_own   = rd_own[q_way] && (wr_pres != '0);
            wr_dirty = rd_dirty[q_way] | (q_op == OP_WB);
            fin_excl = 1'b0;
         end
      endcase
   end

   assign wr_en     = (state_q == ST_FIN) && (q_fill || q_hit);
   assign req_ready = (state_q == ST_IDLE);
   assign rsp_valid = (state_q == ST_FIN);
   assign rsp_core  = q_core;
   assign rsp_addr  = q_addr;
   assign rsp_excl  = rsp_valid && fin_excl;
   assign rsp_src   = q_fill ? SRC_MEM : (q_probed ? SRC_PROBE : SRC_LLC);

   assign prb_valid = (state_q == ST_PRB) && p_any;
   assign prb_core  = p_idx;
   assign prb_inval = q_inval;
   assign prb_addr  = q_fill ? {q_vtag, set} : q_addr;

   assign mem_valid = (state_q == ST_MWR) || (state_q == ST_MRD);
   assign mem_write = (state_q == ST_MWR);
   assign mem_addr  = mem_write ? {q_vtag, set} : q_addr;

   // R6/R7: probes go only to recorded holders of the entry being worked on
   p_probe_holder_r6: assert property (@(posedge clk) disable iff (!rst_n)
      prb_valid |-> rd_pres[q_way][prb_core])
      else $error("probe sent to a core without a presence bit");

   // R7: memory traffic waits for all back-invalidations
   p_mem_after_probes_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_valid |-> (pmask == '0))
      else $error("memory request while probes are pending");

   // R9: one channel active per cycle
   p_one_channel_r9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({prb_valid, mem_valid, rsp_valid}))
      else $error("more than one outgoing channel active");

   // R9: the controller is free again right after a response
   p_idle_after_rsp_r9: assert property (@(posedge clk) disable iff (!rst_n)
      rsp_valid |=> req_ready)
      else $error("not idle after response");

   // R11: an exclusive grant leaves the requester as sole holder
   p_excl_sole_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (rsp_valid && rsp_excl) |=> (rd_pres[q_way] == (NCORE'(1) << q_core)))
      else $error("exclusive grant but other holders recorded");
endmodule

// File: tb/sim_incl_dir_ctrl.sv
`timescale 1ns/1ps
module sim_incl_dir_ctrl;
   localparam int NCORE = 4, ADDR_W = 4, SETS = 2, WAYS = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic req_valid = 1'b0, req_ready;
   logic [1:0] req_core = '0, req_op = '0;
   logic [ADDR_W-1:0] req_addr = '0;
   logic rsp_valid, rsp_excl, prb_valid, prb_inval, mem_valid, mem_write;
   logic [1:0] rsp_core, prb_core, rsp_src;
   logic [ADDR_W-1:0] rsp_addr, prb_addr, mem_addr;
   logic prb_ack = 1'b0, prb_ack_dirty = 1'b0, mem_ack = 1'b0;

   always #2.5 clk = ~clk;

   incl_dir_ctrl #(.NCORE(NCORE), .ADDR_W(ADDR_W), .SETS(SETS), .WAYS(WAYS)) u0 (
      .clk, .rst_n, .req_valid, .req_ready, .req_core, .req_op, .req_addr,
      .rsp_valid, .rsp_core, .rsp_addr, .rsp_src, .rsp_excl,
      .prb_valid, .prb_core, .prb_addr, .prb_inval, .prb_ack, .prb_ack_dirty,
      .mem_valid, .mem_write, .mem_addr, .mem_ack
   );

   int n_chk = 0, n_fail = 0;
   int ev [0:31];
   int n_ev = 0;
   logic [NCORE-1:0] dirty_mask = '0;
   int r_src, r_excl;
   bit busy_ok;

   function automatic int ev_p(int core, int inv, int addr);
      return (core << 8) | (inv << 4) | addr;
   endfunction
   function automatic int ev_mr(int addr); return (1 << 12) | addr; endfunction
   function automatic int ev_mw(int addr); return (2 << 12) | addr; endfunction

   task automatic chk(input bit ok, input string tag, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic chk_ev(input int i, input int exp, input string tag);
      chk(i < n_ev && ev[i] == exp, tag, (i < n_ev) ? ev[i] : -1, exp);
   endtask

   // event log of probes and memory requests
   initial forever begin
      @(negedge clk);
      if (prb_valid && n_ev < 32) begin
         ev[n_ev] = ev_p(int'(prb_core), int'(prb_inval), int'(prb_addr));
         n_ev++;
      end
      if (mem_valid && n_ev < 32) begin
         ev[n_ev] = mem_write ? ev_mw(int'(mem_addr)) : ev_mr(int'(mem_addr));
         n_ev++;
      end
   end

   // core-side probe responder
   initial forever begin
      @(negedge clk);
      if (prb_ack) begin prb_ack = 1'b0; prb_ack_dirty = 1'b0; end
      if (prb_valid) begin
         logic d;
         d = dirty_mask[prb_core];
         @(negedge clk);
         prb_ack = 1'b1;
         prb_ack_dirty = d;
      end
   end

   // fixed-latency memory model
   initial forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      if (mem_valid) begin
         @(negedge clk);
         @(negedge clk);
         mem_ack = 1'b1;
      end
   end

   task automatic do_req(input int core, input int op, input int addr);
      n_ev = 0;
      busy_ok = 1'b1;
      @(negedge clk);
      req_valid = 1'b1;
      req_core = 2'(core);
      req_op = 2'(op);
      req_addr = ADDR_W'(addr);
      @(posedge clk);
      @(negedge clk);
      req_valid = 1'b0;
      while (!rsp_valid) begin
         if (req_ready) busy_ok = 1'b0;
         @(negedge clk);
      end
      if (req_ready) busy_ok = 1'b0;
      r_src = int'(rsp_src);
      r_excl = int'(rsp_excl);
      chk(busy_ok, "R9 ready low while busy", int'(busy_ok), 1);
   endtask

   initial begin
      #(200000 * 5);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      chk(req_ready === 1'b1, "R1 ready after reset", int'(req_ready), 1);
      chk({prb_valid, mem_valid, rsp_valid} === 3'b000, "R1 outputs idle",
          int'({prb_valid, mem_valid, rsp_valid}), 0);

      // R1 R2 R11: first read of line 2 goes to memory only
      do_req(0, 0, 2);
      chk(n_ev == 1, "R2 miss event count", n_ev, 1);
      chk_ev(0, ev_mr(2), "R2 memory read of line");
      chk(r_src == 2, "R2 source memory", r_src, 2);
      chk(r_excl == 1, "R11 sole holder exclusive", r_excl, 1);

      // R4: read of a line owned by core 0, which returns dirty data
      dirty_mask = 4'b0001;
      do_req(1, 0, 2);
      dirty_mask = '0;
      chk(n_ev == 1, "R4 single probe", n_ev, 1);
      chk_ev(0, ev_p(0, 0, 2), "R4 downgrade probe to owner");
      chk(r_src == 1, "R4 source probe", r_src, 1);
      chk(r_excl == 0, "R4 shared grant", r_excl, 0);

      // R3: shared line answered directly
      do_req(2, 0, 2);
      chk(n_ev == 0, "R3 no probe on shared hit", n_ev, 0);
      chk(r_src == 0, "R3 source shared cache", r_src, 0);
      chk(r_excl == 0, "R11 others hold", r_excl, 0);

      // R6: ownership request invalidates holders 0,1,2 in order
      do_req(3, 1, 2);
      chk(n_ev == 3, "R6 probe count", n_ev, 3);
      chk_ev(0, ev_p(0, 1, 2), "R6 first invalidate");
      chk_ev(1, ev_p(1, 1, 2), "R6 second invalidate");
      chk_ev(2, ev_p(2, 1, 2), "R6 third invalidate");
      chk(r_src == 1 && r_excl == 1, "R6 response", r_src * 10 + r_excl, 11);

      // R6: repeat with no other holder
      do_req(3, 1, 2);
      chk(n_ev == 0, "R6 no probe when sole", n_ev, 0);
      chk(r_src == 0 && r_excl == 1, "R6 direct response", r_src * 10 + r_excl, 1);

      // R8: eviction notice clears the bit
      do_req(3, 3, 2);
      chk(n_ev == 0 && r_src == 0 && r_excl == 0, "R8 evict response",
          n_ev * 100 + r_src * 10 + r_excl, 0);
      do_req(1, 0, 2);
      chk(n_ev == 0, "R8 no probe after evict", n_ev, 0);
      chk(r_src == 0 && r_excl == 1, "R8 R11 sole reader", r_src * 10 + r_excl, 1);

      // R10: empty way used first
      do_req(2, 0, 4);
      chk(n_ev == 1, "R10 fill without eviction", n_ev, 1);
      chk_ev(0, ev_mr(4), "R10 read of new line");

      // R5 R7 R10: pointer selects way 0 (line 2, dirty, held by core 1)
      do_req(0, 0, 6);
      chk(n_ev == 3, "R5 dirty eviction events", n_ev, 3);
      chk_ev(0, ev_p(1, 1, 2), "R7 back-invalidate holder");
      chk_ev(1, ev_mw(2), "R5 writeback before fill");
      chk_ev(2, ev_mr(6), "R5 fill after writeback");
      chk(r_src == 2 && r_excl == 1, "R2 fill response", r_src * 10 + r_excl, 21);

      // R7 R10: pointer now way 1 (line 4, clean, core 2)
      do_req(3, 0, 8);
      chk(n_ev == 2, "R7 clean eviction events", n_ev, 2);
      chk_ev(0, ev_p(2, 1, 4), "R7 back-invalidate clean holder");
      chk_ev(1, ev_mr(8), "R7 no memory write for clean victim");

      // R8 R5: writeback leaves a dirty line without holders
      do_req(0, 2, 6);
      chk(n_ev == 0 && r_src == 0 && r_excl == 0, "R8 writeback response",
          n_ev * 100 + r_src * 10 + r_excl, 0);
      do_req(1, 0, 10);
      chk(n_ev == 2, "R5 writeback-only eviction", n_ev, 2);
      chk_ev(0, ev_mw(6), "R5 dirty line written, no probe");
      chk_ev(1, ev_mr(10), "R5 fill follows");

      // sweep: every core reads line 1, then core 0 takes ownership
      for (int c = 0; c < NCORE; c++) begin
         do_req(c, 0, 1);
         if (c == 0) begin
            chk_ev(0, ev_mr(1), "R2 sweep first reader");
            chk(r_src == 2 && r_excl == 1, "R11 sweep first grant", r_src * 10 + r_excl, 21);
         end else if (c == 1) begin
            chk_ev(0, ev_p(0, 0, 1), "R4 sweep owner downgrade");
            chk(r_src == 1 && r_excl == 0, "R4 sweep response", r_src * 10 + r_excl, 10);
         end else begin
            chk(n_ev == 0, "R3 sweep shared reader", n_ev, 0);
            chk(r_src == 0 && r_excl == 0, "R3 sweep response", r_src * 10 + r_excl, 0);
         end
      end
      do_req(0, 1, 1);
      chk(n_ev == NCORE - 1, "R6 sweep probe count", n_ev, NCORE - 1);
      for (int c = 1; c < NCORE; c++)
         chk_ev(c - 1, ev_p(c, 1, 1), "R6 sweep ascending invalidate");
      chk(r_src == 1 && r_excl == 1, "R6 sweep response", r_src * 10 + r_excl, 11);

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule